// File: doc/BRIEF.md
# Rational 3:2 Polyphase Resampler

This block takes a stereo stream of signed left/right sample pairs at one rate and produces a stream at three halves of that rate, for example 32 kHz in and 48 kHz out. In principle it inserts two zero samples after every input sample, runs the result through a low-pass FIR, scales it up by three to make up for the energy lost to the inserted zeros, and keeps every second filtered sample. In practice the chain is folded into a polyphase schedule. Each output uses only the one filter branch whose taps line up with real input samples, and outputs that decimation would discard are never computed. One millisecond of 64 input pairs therefore yields exactly 96 output pairs.

Both channels share a single multiply-accumulate unit, one tap per clock. Each channel has its own sample history. The products are summed in a wide accumulator, then gain-compensated, rounded to nearest and clipped to the sample width. The filter kernel is a fixed constant set that is computed at elaboration from the parameters. Input and output both use a valid/ready handshake.

Top module: `rsmp_3to2`

## Requirements
- R1: `in_ready` is high only while the block is idle. After a pair is accepted, `in_ready` stays low until every output pair due for that input has been taken. An accepted pair becomes the newest entry (branch position 0) of its channel's history, and the older entries move one position back.
- R2: Accepted inputs are numbered from 0 after reset. An even-numbered input yields two output pairs, from filter branches 0 and then 2. An odd-numbered input yields one pair, from branch 1. So 64 inputs give 96 outputs, and `in_ready` is high again once the last pair for an input is taken.
- R3: For branch p and newest input index i, each output equals saturate(floor((3·S + 2^(FRAC−1)) / 2^FRAC)) with FRAC = 17, where S = Σ_{j=0..TAPS−1} h[p+3j]·x[i−j] and x at a negative index is 0. This is rounding to nearest with ties toward +∞.
- R4: The kernel has 3·TAPS coefficients h[k] = STEP·min(k+1, 3·TAPS−k), for k = 0 … 3·TAPS−1.
- R5: A rounded result above 2^23−1 is output as 8388607, and one below −2^23 is output as −8388608.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high, `out_l`/`out_r` do not change, and no input is accepted.
- R7: The left output depends only on left inputs and the right output only on right inputs.
- R8: After reset, `in_ready` is 1, `out_valid` is 0, both histories are zero and the input count restarts at 0. This holds even when reset arrives in the middle of a computation.
- R9: `out_valid` rises exactly 2·TAPS clock cycles after the edge that accepted the input, or the edge that took the previous output of the same input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pair offered |
| in_ready | output | 1 | Block can take an input pair |
| in_l | input | DW | Left input sample, signed |
| in_r | input | DW | Right input sample, signed |
| out_valid | output | 1 | Output pair available |
| out_ready | input | 1 | Consumer takes the output pair |
| out_l | output | DW | Left output sample, signed |
| out_r | output | DW | Right output sample, signed |

## Verification
The bench builds the block with TAPS = 4 and STEP = 8000, and keeps the sample, coefficient, accumulator and fraction widths at their defaults. With four taps per branch, a history fills after four inputs and the latency window shrinks to eight cycles, so impulse responses, pseudo-random patterns and a full 64-input frame all stay short. The large step gives every branch a DC gain of about 2.56, so full-scale inputs of either sign drive both saturation limits, which the default kernel (gain just under one) cannot reach.

// File: rtl/rsmp_pkg.sv
package rsmp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_OUT  = 2'd2
  } rsmp_state_e;

  // Triangular kernel: rises by STEP per tap to the centre, then falls back.
  function automatic int tap_coef(input int k, input int len, input int step);
    int rise;
    int fall;
    rise = k + 1;
    fall = len - k;
    return step * ((rise < fall) ? rise : fall);
  endfunction

endpackage

// File: rtl/rsmp_hist.sv
module rsmp_hist #(
  parameter int DW   = 24,
  parameter int TAPS = 16,
  parameter int IW   = (TAPS > 1) ? $clog2(TAPS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 shift_en,
  input  logic signed [DW-1:0] din,
  input  logic [IW-1:0]        rd_idx,
  output logic signed [DW-1:0] dout
);

  logic signed [DW-1:0] line [TAPS];

  for (genvar g = 0; g < TAPS; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        line[g] <= '0;
        else if (shift_en) line[g] <= din;
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        line[g] <= '0;
        else if (shift_en) line[g] <= line[g-1];
      end
    end
  end

  assign dout = line[rd_idx];

endmodule

// File: rtl/rsmp_seq.sv
module rsmp_seq
  import rsmp_pkg::*;
#(
  parameter int TAPS = 16,
  parameter int IW   = (TAPS > 1) ? $clog2(TAPS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          out_ready,
  output logic          in_ready,
  output logic          out_valid,
  output logic          in_fire,
  output logic          out_fire,
  output logic          mac_en,
  output logic          mac_ch,
  output logic [IW-1:0] mac_idx,
  output logic          mac_last,
  output logic [1:0]    phase
);

  localparam logic [IW-1:0] LAST_IDX = IW'(TAPS - 1);

  rsmp_state_e st;
  logic        parity;

  assign in_ready  = (st == ST_IDLE);
  assign out_valid = (st == ST_OUT);
  assign in_fire   = in_valid & in_ready;
  assign out_fire  = out_valid & out_ready;
  assign mac_en    = (st == ST_RUN);
  assign mac_last  = mac_en && (mac_idx == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      parity  <= 1'b0;
      phase   <= 2'd0;
      mac_idx <= '0;
      mac_ch  <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (in_fire) begin
            st      <= ST_RUN;
            phase   <= parity ? 2'd1 : 2'd0;
            parity  <= ~parity;
            mac_idx <= '0;
            mac_ch  <= 1'b0;
          end
        end
        ST_RUN: begin
          if (mac_idx == LAST_IDX) begin
            mac_idx <= '0;
            if (mac_ch) begin
              mac_ch <= 1'b0;
              st     <= ST_OUT;
            end else begin
              mac_ch <= 1'b1;
            end
          end else begin
            mac_idx <= mac_idx + 1'b1;
          end
        end
        ST_OUT: begin
          if (out_ready) begin
            if (phase == 2'd0) begin
              phase <= 2'd2;
              st    <= ST_RUN;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rsmp_mac.sv
module rsmp_mac
  import rsmp_pkg::*;
#(
  parameter int DW   = 24,
  parameter int CW   = 18,
  parameter int AW   = 48,
  parameter int FRAC = 17,
  parameter int TAPS = 16,
  parameter int STEP = 218,
  parameter int IW   = (TAPS > 1) ? $clog2(TAPS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 ch,
  input  logic [IW-1:0]        idx,
  input  logic                 last,
  input  logic [1:0]           phase,
  input  logic signed [DW-1:0] sample,
  output logic signed [DW-1:0] res_l,
  output logic signed [DW-1:0] res_r,
  output logic                 fin,
  output logic                 clip_hi,
  output logic                 clip_lo
);

  localparam int LEN = 3 * TAPS;
  localparam int KW  = $clog2(LEN);
  localparam int PW  = DW + CW;
  localparam logic signed [AW-1:0] HALF = AW'(1) << (FRAC - 1);
  localparam logic signed [AW-1:0] SMAX = {{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [AW-1:0] SMIN = {{(AW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  // Gain of three for the zero-stuffing loss, then round half up and drop FRAC bits.
  function automatic logic signed [AW-1:0] gain_round(input logic signed [AW-1:0] a);
    logic signed [AW-1:0] g;
    g = (a <<< 1) + a + HALF;
    return g >>> FRAC;
  endfunction

  function automatic logic signed [DW-1:0] clip(input logic signed [AW-1:0] v);
    if (v > SMAX)      return SMAX[DW-1:0];
    else if (v < SMIN) return SMIN[DW-1:0];
    else               return v[DW-1:0];
  endfunction

  logic signed [CW-1:0] rom [LEN];
  for (genvar g = 0; g < LEN; g++) begin : g_rom
    assign rom[g] = CW'(tap_coef(g, LEN, STEP));
  end

  logic [KW-1:0]        tap_sel;
  logic signed [CW-1:0] coef;
  logic signed [PW-1:0] prod;
  logic signed [AW-1:0] prod_x;
  logic signed [AW-1:0] acc;
  logic signed [AW-1:0] sum;
  logic signed [AW-1:0] scaled;
  logic signed [DW-1:0] result;

  assign tap_sel = KW'(int'(phase) + 3 * int'(idx));
  assign coef    = rom[tap_sel];
  assign prod    = sample * coef;
  assign prod_x  = {{(AW-PW){prod[PW-1]}}, prod};
  assign sum     = acc + prod_x;
  assign scaled  = gain_round(sum);
  assign result  = clip(scaled);
  assign fin     = en && last;
  assign clip_hi = fin && (scaled > SMAX);
  assign clip_lo = fin && (scaled < SMIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc   <= '0;
      res_l <= '0;
      res_r <= '0;
    end else if (en) begin
      if (last) begin
        acc <= '0;
        if (ch) res_r <= result;
        else    res_l <= result;
      end else begin
        acc <= sum;
      end
    end
  end

endmodule

// File: rtl/rsmp_3to2.sv
module rsmp_3to2
  import rsmp_pkg::*;
#(
  parameter int DW   = 24,
  parameter int CW   = 18,
  parameter int AW   = 48,
  parameter int FRAC = 17,
  parameter int TAPS = 16,
  parameter int STEP = 218
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_l,
  input  logic signed [DW-1:0] in_r,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [DW-1:0] out_l,
  output logic signed [DW-1:0] out_r
);

  localparam int IW = (TAPS > 1) ? $clog2(TAPS) : 1;

  logic          in_fire;
  logic          out_fire;
  logic          mac_en;
  logic          mac_ch;
  logic [IW-1:0] mac_idx;
  logic          mac_last;
  logic [1:0]    phase;
  logic          fin;
  logic          clip_hi;
  logic          clip_lo;

  logic signed [DW-1:0] h_din  [2];
  logic signed [DW-1:0] h_dout [2];
  logic signed [DW-1:0] sample;

  assign h_din[0] = in_l;
  assign h_din[1] = in_r;

  rsmp_seq #(.TAPS(TAPS), .IW(IW)) i_seq (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .out_ready(out_ready),
    .in_ready(in_ready), .out_valid(out_valid),
    .in_fire(in_fire), .out_fire(out_fire),
    .mac_en(mac_en), .mac_ch(mac_ch), .mac_idx(mac_idx),
    .mac_last(mac_last), .phase(phase)
  );

  for (genvar c = 0; c < 2; c++) begin : g_chan
    rsmp_hist #(.DW(DW), .TAPS(TAPS), .IW(IW)) i_hist (
      .clk(clk), .rst_n(rst_n), .shift_en(in_fire),
      .din(h_din[c]), .rd_idx(mac_idx), .dout(h_dout[c])
    );
  end

  assign sample = mac_ch ? h_dout[1] : h_dout[0];

  rsmp_mac #(
    .DW(DW), .CW(CW), .AW(AW), .FRAC(FRAC),
    .TAPS(TAPS), .STEP(STEP), .IW(IW)
  ) i_mac (
    .clk(clk), .rst_n(rst_n),
    .en(mac_en), .ch(mac_ch), .idx(mac_idx), .last(mac_last),
    .phase(phase), .sample(sample),
    .res_l(out_l), .res_r(out_r),
    .fin(fin), .clip_hi(clip_hi), .clip_lo(clip_lo)
  );

endmodule

// File: rtl/rsmp_3to2_chk.sv
module rsmp_3to2_chk #(
  parameter int DW   = 24,
  parameter int TAPS = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_ready,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic signed [DW-1:0] out_l,
  input logic signed [DW-1:0] out_r,
  input logic                 in_fire,
  input logic                 out_fire,
  input logic [1:0]           phase,
  input logic                 fin,
  input logic                 mac_ch,
  input logic                 clip_hi,
  input logic                 clip_lo
);

  localparam logic signed [DW-1:0] TOP = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] BOT = {1'b1, {(DW-1){1'b0}}};

  logic [15:0] gap;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 gap <= '0;
    else if (in_fire || out_fire) gap <= '0;
    else if (gap != 16'hFFFF)   gap <= gap + 16'd1;
  end

  assert_busy_after_take_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |=> !in_ready);

  assert_branch_two_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fire && phase == 2'd0) |=> (!in_ready && phase == 2'd2));

  assert_back_to_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fire && phase != 2'd0) |=> in_ready);

  assert_clip_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && clip_hi && !mac_ch) |=> (out_l == TOP));

  assert_clip_bottom_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && clip_lo && mac_ch) |=> (out_r == BOT));

  assert_hold_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_l) && $stable(out_r) && !in_ready));

  assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (gap == 16'(2 * TAPS)));

endmodule

bind rsmp_3to2 rsmp_3to2_chk #(.DW(DW), .TAPS(TAPS)) i_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_l(out_l), .out_r(out_r),
  .in_fire(in_fire), .out_fire(out_fire), .phase(phase),
  .fin(fin), .mac_ch(mac_ch), .clip_hi(clip_hi), .clip_lo(clip_lo)
);

// File: tb/test_rsmp_3to2.sv
module test_rsmp_3to2;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int T    = 4;
  localparam int STEP = 8000;
  localparam int FRAC = 17;
  localparam int DW   = 24;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_ready, out_valid, out_ready;
  logic signed [DW-1:0] in_l, in_r, out_l, out_r;

  always #4 clk = ~clk;

  rsmp_3to2 #(.TAPS(T), .STEP(STEP)) i_rsmp_3to2 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_l(in_l), .in_r(in_r), .out_valid(out_valid), .out_ready(out_ready),
    .out_l(out_l), .out_r(out_r)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int n_in  = 0;
  int n_out = 0;
  bit done  = 1'b0;
  int hl [0:255];
  int hr [0:255];
  longint last_l, last_r;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint coef(input int k);
    int a;
    int b;
    a = k + 1;
    b = 3 * T - k;
    return longint'(STEP) * longint'((a < b) ? a : b);
  endfunction

  function automatic longint model(input int p, input bit right);
    longint s;
    longint v;
    s = 0;
    for (int j = 0; j < T; j++) begin
      if (n_in - j >= 0)
        s += coef(p + 3 * j) * longint'(right ? hr[n_in - j] : hl[n_in - j]);
    end
    v = (s * 3 + (longint'(1) <<< (FRAC - 1))) >>> FRAC;
    if (v > 8388607)  v = 8388607;
    if (v < -8388608) v = -8388608;
    return v;
  endfunction

  task automatic do_reset();
    in_valid = 1'b0; out_ready = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    n_in = 0;
    @(negedge clk);
  endtask

  // Feed one pair, take all its outputs, compare them with the model.
  task automatic feed(input int l, input int r, input int hold);
    int np;
    int ph [2];
    int lat;
    longint el, er;
    logic signed [DW-1:0] sl, sr;
    hl[n_in] = l;
    hr[n_in] = r;
    np    = (n_in % 2 == 0) ? 2 : 1;
    ph[0] = (n_in % 2 == 0) ? 0 : 1;
    ph[1] = 2;
    in_l = DW'(l); in_r = DW'(r); in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    for (int k = 0; k < np; k++) begin
      lat = 0;
      while (!out_valid && lat < 8 * T + 20) begin
        @(negedge clk);
        lat++;
      end
      chk(lat == 2 * T, "R9", "output latency", lat, 2 * T);
      el = model(ph[k], 1'b0);
      er = model(ph[k], 1'b1);
      chk(longint'(out_l) == el, "R3", "left value", out_l, el);
      chk(longint'(out_r) == er, "R3", "right value", out_r, er);
      chk(in_ready == 1'b0, "R1", "in_ready while output due", in_ready, 0);
      last_l = out_l; last_r = out_r;
      if (hold > 0) begin
        sl = out_l; sr = out_r;
        repeat (hold) @(negedge clk);
        chk(out_valid && out_l == sl && out_r == sr && !in_ready, "R6",
            "stalled output held", out_l, sl);
      end
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
      n_out++;
    end
    chk(in_ready == 1'b1, "R2", "ready after last output of input", in_ready, 1);
    n_in++;
  endtask

  task automatic t_reset();
    chk(in_ready == 1'b1, "R8", "in_ready after reset", in_ready, 1);
    chk(out_valid == 1'b0, "R8", "out_valid after reset", out_valid, 0);
  endtask

  // R4/R7: impulse on the left reveals the kernel; right carries its own level.
  task automatic t_impulse();
    feed(100000, -500, 0);
    for (int i = 0; i < 5; i++) feed(0, -500, 0);
  endtask

  task automatic t_pattern();
    for (int i = 0; i < 10; i++)
      feed(((i * 7919) % 4001 - 2000) * 1024, -((i * 3571) % 2999) * 700 + i * 333, 0);
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 5; i++) feed(8388607, -8388608, 0);
    chk(last_l == 8388607, "R5", "left clipped high", last_l, 8388607);
    chk(last_r == -8388608, "R5", "right clipped low", last_r, -8388608);
  endtask

  task automatic t_backpressure();
    feed(300000, 200000, 6);
    feed(-250000, 90000, 3);
  endtask

  task automatic t_midreset();
    feed(500000, 500000, 0);
    in_l = DW'(700000); in_r = DW'(-700000); in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    do_reset();
    chk(in_ready == 1'b1, "R8", "in_ready after mid-run reset", in_ready, 1);
    chk(out_valid == 1'b0, "R8", "out_valid after mid-run reset", out_valid, 0);
    // history must be clear (R1/R8): a zero input must give zero outputs
    feed(0, 0, 0);
    chk(last_l == 0 && last_r == 0, "R8", "history cleared", last_l, 0);
    feed(40000, -40000, 0);
  endtask

  task automatic t_frame();
    int base;
    do_reset();
    base = n_out;
    for (int i = 0; i < 64; i++) feed((i * 131071) % 1000003 - 500000, 250000 - i * 7777, 0);
    chk(n_out - base == 96, "R2", "outputs per 64-input frame", n_out - base, 96);
  endtask

  initial begin
    in_valid = 1'b0; out_ready = 1'b0; in_l = '0; in_r = '0;
    do_reset();
    t_reset();
    t_impulse();
    t_pattern();
    t_saturate();
    t_backpressure();
    t_midreset();
    t_frame();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R2 watchdog expired: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule